// File: doc/BRIEF.md
# Ethernet Receive Pause Handler

This block sits beside the receive path of a full-duplex Ethernet MAC and looks for flow-control Pause frames. It parses each incoming frame's destination address, length/type field, opcode and pause quanta from a byte stream. When the end-of-frame status arrives, it decides whether the frame is a valid pause request. A valid request holds off the local transmitter for the requested number of slot times, where one slot is 64 byte times. A later valid pause frame reloads the count, and a zero quanta value cancels it.

For every MAC control frame (length/type 0x8808), the block also makes a one-cycle decision on whether that frame goes on to the application. A two-bit forwarding mode sets the policy. Turning flow control off, or leaving full duplex, cancels any pause in progress.

Top module: `eth_rx_pause`

## Requirements
- R1: After a synchronous reset, `tx_pause` is 0, `pause_left` is 0 and `ctrl_valid` is 0.
- R2: A pause is honoured only while `cfg_fc_en` and `cfg_full_dup` are both 1. In any other state, no frame starts a pause.
- R3: A frame whose destination address (bytes 0..5, first byte most significant) equals 01-80-C2-00-00-01 is a pause candidate. Any other destination is not a candidate, except as allowed by R4.
- R4: When `cfg_ucast_en` is 1, a frame whose destination equals `cfg_station_addr` is also a pause candidate. When `cfg_ucast_en` is 0, such a frame is not a candidate.
- R5: A pause candidate is honoured only if all of the following hold:
  - bytes 12..13 are 0x8808;
  - bytes 14..15 are 0x0001;
  - `eof_len` is exactly 64;
  - `eof_crc_err` is 0.
  The quanta is taken from bytes 16..17, big-endian. A frame that fails any of these conditions leaves the pause state unchanged.
- R6: For an honoured frame, the quanta appears on `pause_left`, and `tx_pause` rises, on the second rising edge after the cycle in which `rx_eof` is high.
- R7: While paused, `pause_left` decrements once for every 64 cycles with `byte_tick` high. `tx_pause` falls on the same edge at which `pause_left` reaches 0.
- R8: An honoured frame that arrives during a pause replaces the remaining count with its own quanta. A quanta of 0 ends the pause at once.
- R9: While `cfg_fc_en` is 0 or `cfg_full_dup` is 0, `pause_left` and `tx_pause` are held at 0 from the next edge onward.
- R10: On the edge after a `rx_eof` cycle whose frame had length/type 0x8808, `ctrl_valid` pulses for one cycle. `ctrl_fwd` is set by `cfg_ctrl_mode` as follows:
  - 0: never forward;
  - 1: forward unless the opcode is 0x0001;
  - 2: always forward;
  - 3: forward only if the destination is the reserved address or `cfg_station_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive byte qualifier |
| rx_sof | input | 1 | Marks the first byte of a frame (with `rx_valid`) |
| rx_data | input | 8 | Receive byte, in wire order |
| rx_eof | input | 1 | End-of-frame status strobe |
| eof_len | input | 16 | Frame byte count, valid with `rx_eof` |
| eof_crc_err | input | 1 | CRC error flag, valid with `rx_eof` |
| byte_tick | input | 1 | One pulse per byte time on the line |
| cfg_fc_en | input | 1 | Enables receive flow control |
| cfg_full_dup | input | 1 | Link is full duplex |
| cfg_ucast_en | input | 1 | Also accept pause frames sent to the station address |
| cfg_station_addr | input | 48 | Station MAC address, first wire byte in bits 47:40 |
| cfg_ctrl_mode | input | 2 | Forwarding policy for control frames |
| tx_pause | output | 1 | Holds off the transmitter |
| pause_left | output | 16 | Remaining pause, in slots |
| ctrl_valid | output | 1 | One-cycle control-frame decision strobe |
| ctrl_fwd | output | 1 | Forward decision, valid with `ctrl_valid` |

## Verification
On every cycle, the assertions check the following:
- The pause count never rises except on a load, and falls by at most one per cycle.
- A load installs exactly the quanta it carries.
- Leaving the enabled full-duplex state clears the count and `tx_pause` on the next edge.
- A load only ever follows an end-of-frame strobe.
- Mode 0 never forwards.

Only the bench scenarios can show the following:
- Which combinations of address, type, opcode, length, CRC and configuration actually start a pause, and the forwarding decision under each mode.
- The exact 64-tick slot timing.
- Reload, cancellation by a zero quanta, and the fact that rejected frames leave a running pause untouched.

// File: rtl/eth_pause_pkg.sv
package eth_pause_pkg;
  localparam logic [47:0] PAUSE_GROUP_DA = 48'h0180C2000001;
  localparam logic [15:0] MAC_CTRL_TYPE  = 16'h8808;
  localparam logic [15:0] PAUSE_OPCODE   = 16'h0001;

  typedef enum logic [1:0] {
    FWD_NONE       = 2'd0,
    FWD_NON_PAUSE  = 2'd1,
    FWD_ALL        = 2'd2,
    FWD_ADDR_MATCH = 2'd3
  } ctrl_fwd_e;
endpackage

// File: rtl/eth_pause_parser.sv
module eth_pause_parser
  import eth_pause_pkg::*;
#(
  parameter int IDX_W     = 5,
  parameter int LEN_W     = 16,
  parameter int Q_W       = 16,
  parameter int FRAME_LEN = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic [7:0]       rx_data,
  input  logic             rx_eof,
  input  logic [LEN_W-1:0] eof_len,
  input  logic             eof_crc_err,
  input  logic             active,
  input  logic             ucast_en,
  input  logic [47:0]      station_addr,
  input  logic [1:0]       ctrl_mode,
  output logic             pause_load,
  output logic [Q_W-1:0]   pause_quanta,
  output logic             ctrl_valid,
  output logic             ctrl_fwd
);
  localparam logic [IDX_W-1:0] IDX_MAX   = {IDX_W{1'b1}};
  localparam logic [IDX_W-1:0] MIN_BYTES = IDX_W'(18);

  logic [IDX_W-1:0] idx_q, cur_idx;
  logic [47:0]      da_q;
  logic [15:0]      type_q, op_q;
  logic [Q_W-1:0]   qnt_q;
  logic             open_q;

  assign cur_idx = rx_sof ? '0 : idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      da_q   <= '0;
      type_q <= '0;
      op_q   <= '0;
      qnt_q  <= '0;
      open_q <= 1'b0;
    end else begin
      if (rx_valid) begin
        idx_q <= (cur_idx == IDX_MAX) ? IDX_MAX : cur_idx + 1'b1;
        if (rx_sof) open_q <= 1'b1;
        if (cur_idx < IDX_W'(6)) da_q <= {da_q[39:0], rx_data};
        case (cur_idx)
          IDX_W'(12): type_q[15:8] <= rx_data;
          IDX_W'(13): type_q[7:0]  <= rx_data;
          IDX_W'(14): op_q[15:8]   <= rx_data;
          IDX_W'(15): op_q[7:0]    <= rx_data;
          IDX_W'(16): qnt_q        <= {rx_data, qnt_q[7:0]};
          IDX_W'(17): qnt_q        <= {qnt_q[Q_W-1:8], rx_data};
          default: ;
        endcase
      end
      if (rx_eof) open_q <= 1'b0;
    end
  end

  logic is_group, is_own, is_ctrl, is_pause_op, frame_ok, honour, fwd_c;
  ctrl_fwd_e mode;

  assign mode        = ctrl_fwd_e'(ctrl_mode);
  assign is_group    = (da_q == PAUSE_GROUP_DA);
  assign is_own      = (da_q == station_addr);
  assign is_ctrl     = (type_q == MAC_CTRL_TYPE);
  assign is_pause_op = (op_q == PAUSE_OPCODE);
  assign frame_ok    = rx_eof && open_q && (idx_q >= MIN_BYTES);
  assign honour      = active && (is_group || (ucast_en && is_own)) && is_ctrl &&
                       is_pause_op && (eof_len == LEN_W'(FRAME_LEN)) && !eof_crc_err;

  always_comb begin
    case (mode)
      FWD_NONE:       fwd_c = 1'b0;
      FWD_NON_PAUSE:  fwd_c = !is_pause_op;
      FWD_ALL:        fwd_c = 1'b1;
      default:        fwd_c = is_group || is_own;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pause_load   <= 1'b0;
      pause_quanta <= '0;
      ctrl_valid   <= 1'b0;
      ctrl_fwd     <= 1'b0;
    end else begin
      pause_load   <= frame_ok && honour;
      pause_quanta <= qnt_q;
      ctrl_valid   <= frame_ok && is_ctrl;
      ctrl_fwd     <= frame_ok && is_ctrl && fwd_c;
    end
  end

  // R6
  load_after_eof_chk: assert property (@(posedge clk) disable iff (rst)
    pause_load |-> $past(rx_eof));

  // R10
  mode_none_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_valid && $past(ctrl_mode) == 2'd0) |-> !ctrl_fwd);
endmodule

// File: rtl/eth_pause_timer.sv
module eth_pause_timer #(
  parameter int Q_W        = 16,
  parameter int SLOT_BYTES = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           active,
  input  logic           load,
  input  logic [Q_W-1:0] quanta,
  input  logic           byte_tick,
  output logic           tx_pause,
  output logic [Q_W-1:0] count
);
  localparam int PS_W = (SLOT_BYTES > 1) ? $clog2(SLOT_BYTES) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(SLOT_BYTES - 1);

  logic [PS_W-1:0] presc_q;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      count    <= '0;
      presc_q  <= '0;
      tx_pause <= 1'b0;
    end else if (load) begin
      count    <= quanta;
      presc_q  <= '0;
      tx_pause <= (quanta != '0);
    end else if (byte_tick && count != '0) begin
      if (presc_q == PS_LAST) begin
        presc_q  <= '0;
        count    <= count - 1'b1;
        tx_pause <= (count != Q_W'(1));
      end else begin
        presc_q <= presc_q + 1'b1;
      end
    end
  end

  // R9
  inactive_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> (count == '0 && !tx_pause));

  // R7
  no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> (count <= $past(count)));

  // R7
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && active) |=> (count == $past(count) || count == $past(count) - 1'b1));

  // R8
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    (load && active) |=> (count == $past(quanta)));
endmodule

// File: rtl/eth_rx_pause.sv
module eth_rx_pause #(
  parameter int LEN_W      = 16,
  parameter int Q_W        = 16,
  parameter int SLOT_BYTES = 64,
  parameter int FRAME_LEN  = 64,
  parameter int IDX_W      = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic [7:0]       rx_data,
  input  logic             rx_eof,
  input  logic [LEN_W-1:0] eof_len,
  input  logic             eof_crc_err,
  input  logic             byte_tick,
  input  logic             cfg_fc_en,
  input  logic             cfg_full_dup,
  input  logic             cfg_ucast_en,
  input  logic [47:0]      cfg_station_addr,
  input  logic [1:0]       cfg_ctrl_mode,
  output logic             tx_pause,
  output logic [Q_W-1:0]   pause_left,
  output logic             ctrl_valid,
  output logic             ctrl_fwd
);
  logic           active;
  logic           load;
  logic [Q_W-1:0] quanta;

  assign active = cfg_fc_en && cfg_full_dup;

  eth_pause_parser #(
    .IDX_W(IDX_W), .LEN_W(LEN_W), .Q_W(Q_W), .FRAME_LEN(FRAME_LEN)
  ) u_parser (
    .clk(clk), .rst(rst),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
    .rx_eof(rx_eof), .eof_len(eof_len), .eof_crc_err(eof_crc_err),
    .active(active), .ucast_en(cfg_ucast_en), .station_addr(cfg_station_addr),
    .ctrl_mode(cfg_ctrl_mode),
    .pause_load(load), .pause_quanta(quanta),
    .ctrl_valid(ctrl_valid), .ctrl_fwd(ctrl_fwd)
  );

  eth_pause_timer #(.Q_W(Q_W), .SLOT_BYTES(SLOT_BYTES)) u_timer (
    .clk(clk), .rst(rst), .active(active), .load(load), .quanta(quanta),
    .byte_tick(byte_tick), .tx_pause(tx_pause), .count(pause_left)
  );
endmodule

// File: tb/eth_rx_pause_test.sv
`timescale 1ns/1ps
module eth_rx_pause_test;
  localparam logic [47:0] GRP   = 48'h0180C2000001;
  localparam logic [47:0] OWN   = 48'h021122334455;
  localparam logic [47:0] OTHER = 48'h0180C2000002;

  logic clk = 0, rst = 1;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, eof_crc_err = 0, byte_tick = 0;
  logic [7:0] rx_data = 0;
  logic [15:0] eof_len = 0;
  logic cfg_fc_en = 0, cfg_full_dup = 0, cfg_ucast_en = 0;
  logic [47:0] cfg_station_addr = OWN;
  logic [1:0] cfg_ctrl_mode = 0;
  logic tx_pause, ctrl_valid, ctrl_fwd;
  logic [15:0] pause_left;
  int checks = 0, failures = 0;
  logic got_valid, got_fwd;

  always #4 clk = ~clk;

  eth_rx_pause uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
    .rx_eof(rx_eof), .eof_len(eof_len), .eof_crc_err(eof_crc_err),
    .byte_tick(byte_tick), .cfg_fc_en(cfg_fc_en), .cfg_full_dup(cfg_full_dup),
    .cfg_ucast_en(cfg_ucast_en), .cfg_station_addr(cfg_station_addr),
    .cfg_ctrl_mode(cfg_ctrl_mode), .tx_pause(tx_pause), .pause_left(pause_left),
    .ctrl_valid(ctrl_valid), .ctrl_fwd(ctrl_fwd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] da, input logic [15:0] typ, input logic [15:0] op,
                      input logic [15:0] q, input logic [15:0] len, input logic crc);
    for (int i = 0; i < 20; i++) begin
      rx_valid = 1; rx_sof = (i == 0);
      if (i < 6)       rx_data = da[47 - 8*i -: 8];
      else if (i < 12) rx_data = 8'hA0 + 8'(i);
      else if (i == 12) rx_data = typ[15:8];
      else if (i == 13) rx_data = typ[7:0];
      else if (i == 14) rx_data = op[15:8];
      else if (i == 15) rx_data = op[7:0];
      else if (i == 16) rx_data = q[15:8];
      else if (i == 17) rx_data = q[7:0];
      else rx_data = 8'h00;
      @(posedge clk); #1;
    end
    rx_valid = 0; rx_sof = 0;
    rx_eof = 1; eof_len = len; eof_crc_err = crc;
    @(posedge clk); #1;
    rx_eof = 0; eof_crc_err = 0;
    got_valid = ctrl_valid; got_fwd = ctrl_fwd;
    @(posedge clk); #1;
  endtask

  task automatic clear_pause();
    cfg_fc_en = 0; @(posedge clk); #1; @(posedge clk); #1;
  endtask

  task automatic ticks(input int n);
    byte_tick = 1;
    repeat (n) @(posedge clk);
    #1 byte_tick = 0;
  endtask

  initial begin
    #(8*200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int it;
    logic [47:0] da;
    logic hon, fwd_e;
    logic [15:0] q, typ, op;
    repeat (3) @(posedge clk); #1;
    // R1 reset state
    check("R1 tx_pause", tx_pause, 0);
    check("R1 pause_left", pause_left, 0);
    check("R1 ctrl_valid", ctrl_valid, 0);
    rst = 0; @(posedge clk); #1;

    it = 0;
    for (int a = 0; a < 3; a++)
    for (int u = 0; u < 2; u++)
    for (int t = 0; t < 2; t++)
    for (int o = 0; o < 2; o++)
    for (int l = 0; l < 2; l++)
    for (int c = 0; c < 2; c++)
    for (int f = 0; f < 2; f++)
    for (int d = 0; d < 2; d++) begin
      da  = (a == 0) ? GRP : (a == 1) ? OWN : OTHER;
      typ = t ? 16'h8808 : 16'h8809;
      op  = o ? 16'h0001 : 16'h0002;
      q   = 16'(it + 1);
      clear_pause();
      cfg_fc_en = f[0]; cfg_full_dup = d[0]; cfg_ucast_en = u[0];
      cfg_ctrl_mode = 2'(it);
      send(da, typ, op, q, l ? 16'd64 : 16'd65, c[0]);
      // R2 R3 R4 R5 acceptance
      hon = f[0] && d[0] && (a == 0 || (u == 1 && a == 1)) && t[0] && o[0] && l[0] && !c[0];
      check("R2/R3/R4/R5 tx_pause", tx_pause, hon);
      // R6 quanta on the second edge
      check("R6 pause_left", pause_left, hon ? q : 16'd0);
      // R10 decision
      case (it % 4)
        0: fwd_e = 0;
        1: fwd_e = !o[0];
        2: fwd_e = 1;
        default: fwd_e = (a != 2);
      endcase
      check("R10 ctrl_valid", got_valid, t[0]);
      check("R10 ctrl_fwd", got_fwd, t[0] && fwd_e);
      it++;
    end

    // R7 slot timing
    clear_pause();
    cfg_fc_en = 1; cfg_full_dup = 1; cfg_ucast_en = 0;
    send(GRP, 16'h8808, 16'h0001, 16'd3, 16'd64, 0);
    ticks(64);  check("R7 after one slot", pause_left, 2);
    ticks(127); check("R7 one tick short", pause_left, 1);
    check("R7 still paused", tx_pause, 1);
    ticks(1);   check("R7 expired", pause_left, 0);
    check("R7 deasserted", tx_pause, 0);

    // R8 reload and cancel
    send(GRP, 16'h8808, 16'h0001, 16'd5, 16'd64, 0);
    ticks(100); check("R8 running", pause_left, 4);
    send(GRP, 16'h8808, 16'h0001, 16'd2, 16'd64, 0);
    check("R8 reload", pause_left, 2);
    // R5 a rejected frame leaves the running pause alone
    send(GRP, 16'h8808, 16'h0001, 16'd9, 16'd64, 1);
    check("R5 crc reject keeps count", pause_left, 2);
    send(GRP, 16'h8808, 16'h0001, 16'd0, 16'd64, 0);
    check("R8 zero cancels", pause_left, 0);
    check("R8 zero deasserts", tx_pause, 0);

    // R9 leaving full duplex clears
    send(GRP, 16'h8808, 16'h0001, 16'd7, 16'd64, 0);
    check("R9 setup", pause_left, 7);
    cfg_full_dup = 0; @(posedge clk); #1;
    check("R9 cleared count", pause_left, 0);
    check("R9 cleared pause", tx_pause, 0);
    cfg_full_dup = 1; @(posedge clk); #1;
    check("R9 stays cleared", pause_left, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule